// File: doc/BRIEF.md
# Auto-Reload PWM Timer with Byte-Split Duty Compare

This block is an up-counting timer with a width of 12 bits by default. When the count is at its maximum and a tick arrives, the timer wraps. It reloads from a programmable start value, so one PWM period lasts `2^CNT_W - reload` ticks. Each wrap is an overflow event. The overflow event starts a new period: the PWM level goes high, and it goes low again when the count matches the duty compare value. A single tick-enable input paces the counter.

Software reaches the block through a byte-wide register port. The reload value and the duty value are each split into a high byte and a low byte. Writing the duty high byte only loads a holding register, and it freezes the compare function. Writing the duty low byte loads the full compare value from the held high part and the new low byte, then unfreezes the compare. A compare that falls inside the frozen window is lost, and the output stays high for that period.

The overflow flag sits in a status register and is cleared by reading that register. While the interrupt-enable bit is set, the flag raises an interrupt request. A PWM enable bit gates the output pin. The counter keeps running while PWM is disabled.

Top module: `arpwm_timer`

## Requirements
- R1: After reset, all six registers read 0, `pwm_o` is low and `irq_o` is low.
- R2: Each cycle with `tick_i` high, the counter adds one. On a tick at the all-ones count, the counter loads the reload value instead, and that tick is the overflow event. The PWM period is therefore `2^CNT_W - reload` ticks.
- R3: At an overflow where duty >= reload, the PWM level goes high. It goes low on the tick where the count equals the duty value, so it is high for `duty - reload + 1` ticks.
- R4: At an overflow where duty < reload, the PWM level goes low and stays low for the whole period.
- R5: A write to the duty high byte (address 2) freezes the compare. While frozen, the PWM level cannot fall, and status bit 1 reads 1.
- R6: A duty high byte write does not change the active duty value; the duty-high register (address 2) still reads the old value. A duty low byte write (address 3) loads `{held high, low}` as the new duty value and clears the freeze.
- R7: The reload value is written as a low byte at address 0 and a high nibble at address 1. A new reload value takes effect only at the next overflow, so the period in progress keeps its length.
- R8: Each overflow sets the overflow flag in status bit 0 (address 5). Reading address 5 returns the flag and then clears it, unless an overflow happens in that same cycle.
- R9: `irq_o` is high exactly when the overflow flag is set and the interrupt-enable bit (control bit 1, address 4) is set.
- R10: While the PWM enable bit (control bit 0) is 0, `pwm_o` is low. The counter and the overflow flag keep working.
- R11: While `tick_i` is low, the count, the PWM level and the overflow flag do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable, one tick per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (clears the flag on a status read) |
| addr_i | input | 3 | Register address: 0 reload lo, 1 reload hi, 2 duty hi, 3 duty lo, 4 control, 5 status |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with its default widths: a 12-bit counter and an 8-bit bus. The first period after reset therefore takes 4096 ticks. After that, the bench programs reload values of 0xFF0 and 0xFE0, which give periods of 16 and 32 cycles. These short periods let it time many high phases and wrap boundaries, and they make reads aligned to an overflow deterministic. With `tick_i` held high, every cycle is a tick, so the high time and the period are measured directly in clock cycles.

// File: rtl/arpwm_pkg.sv
package arpwm_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_RLD_LO  = 3'd0,
    REG_RLD_HI  = 3'd1,
    REG_DUTY_HI = 3'd2,
    REG_DUTY_LO = 3'd3,
    REG_CTRL    = 3'd4,
    REG_STAT    = 3'd5
  } reg_sel_e;

  localparam int CTRL_PWM_EN_BIT = 0;
  localparam int CTRL_IRQ_EN_BIT = 1;
  localparam int STAT_OVF_BIT    = 0;
  localparam int STAT_FRZ_BIT    = 1;

endpackage

// File: rtl/arpwm_regs.sv
module arpwm_regs
  import arpwm_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ovf_evt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic [CNT_W-1:0]  duty_o,
  output logic              frozen_o,
  output logic              pwm_en_o,
  output logic              irq_en_o,
  output logic              ovf_flag_o
);

  localparam int HI_W  = CNT_W - DATA_W;
  localparam int PAD_W = DATA_W - HI_W;

  logic [HI_W-1:0]   rld_hi_q, duty_hi_hold_q, duty_hi_q;
  logic [DATA_W-1:0] rld_lo_q, duty_lo_q;
  logic              frozen_q, pwm_en_q, irq_en_q, ovf_flag_q;

  logic wr_rld_lo, wr_rld_hi, wr_duty_hi, wr_duty_lo, wr_ctrl, rd_stat;

  function automatic logic [DATA_W-1:0] pad_hi(input logic [HI_W-1:0] v);
    return {{PAD_W{1'b0}}, v};
  endfunction

  always_comb begin
    wr_rld_lo  = wr_en_i && (addr_i == REG_RLD_LO);
    wr_rld_hi  = wr_en_i && (addr_i == REG_RLD_HI);
    wr_duty_hi = wr_en_i && (addr_i == REG_DUTY_HI);
    wr_duty_lo = wr_en_i && (addr_i == REG_DUTY_LO);
    wr_ctrl    = wr_en_i && (addr_i == REG_CTRL);
    rd_stat    = rd_en_i && (addr_i == REG_STAT);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rld_lo_q       <= '0;
      rld_hi_q       <= '0;
      duty_lo_q      <= '0;
      duty_hi_q      <= '0;
      duty_hi_hold_q <= '0;
      frozen_q       <= 1'b0;
      pwm_en_q       <= 1'b0;
      irq_en_q       <= 1'b0;
    end else begin
      if (wr_rld_lo) rld_lo_q <= wdata_i;
      if (wr_rld_hi) rld_hi_q <= wdata_i[HI_W-1:0];
      if (wr_duty_hi) begin
        duty_hi_hold_q <= wdata_i[HI_W-1:0];
        frozen_q       <= 1'b1;
      end
      if (wr_duty_lo) begin
        duty_hi_q <= duty_hi_hold_q;
        duty_lo_q <= wdata_i;
        frozen_q  <= 1'b0;
      end
      if (wr_ctrl) begin
        pwm_en_q <= wdata_i[CTRL_PWM_EN_BIT];
        irq_en_q <= wdata_i[CTRL_IRQ_EN_BIT];
      end
    end
  end

  // A new overflow in the same cycle as the status read keeps the flag set.
  always_ff @(posedge clk_i) begin
    if (!rst_ni)        ovf_flag_q <= 1'b0;
    else if (ovf_evt_i) ovf_flag_q <= 1'b1;
    else if (rd_stat)   ovf_flag_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_RLD_LO:  rdata_o = rld_lo_q;
      REG_RLD_HI:  rdata_o = pad_hi(rld_hi_q);
      REG_DUTY_HI: rdata_o = pad_hi(duty_hi_q);
      REG_DUTY_LO: rdata_o = duty_lo_q;
      REG_CTRL: begin
        rdata_o[CTRL_PWM_EN_BIT] = pwm_en_q;
        rdata_o[CTRL_IRQ_EN_BIT] = irq_en_q;
      end
      REG_STAT: begin
        rdata_o[STAT_OVF_BIT] = ovf_flag_q;
        rdata_o[STAT_FRZ_BIT] = frozen_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign reload_o   = {rld_hi_q, rld_lo_q};
  assign duty_o     = {duty_hi_q, duty_lo_q};
  assign frozen_o   = frozen_q;
  assign pwm_en_o   = pwm_en_q;
  assign irq_en_o   = irq_en_q;
  assign ovf_flag_o = ovf_flag_q;

endmodule

// File: rtl/arpwm_counter.sv
module arpwm_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_evt_o
);

  logic [CNT_W-1:0] cnt_q;

  function automatic logic at_top(input logic [CNT_W-1:0] c);
    return &c;
  endfunction

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c,
                                            input logic [CNT_W-1:0] rld);
    return at_top(c) ? rld : c + CNT_W'(1);
  endfunction

  assign ovf_evt_o = tick_i && at_top(cnt_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= step(cnt_q, reload_i);
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/arpwm_compare.sv
module arpwm_compare #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ovf_evt_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             frozen_i,
  input  logic             pwm_en_i,
  output logic             cmp_evt_o,
  output logic             pwm_lvl_o,
  output logic             pwm_o
);

  logic lvl_q;

  function automatic logic opens_high(input logic [CNT_W-1:0] duty,
                                      input logic [CNT_W-1:0] rld);
    return duty >= rld;
  endfunction

  assign cmp_evt_o = tick_i && !ovf_evt_i && !frozen_i && (cnt_i == duty_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)        lvl_q <= 1'b0;
    else if (ovf_evt_i) lvl_q <= opens_high(duty_i, reload_i);
    else if (cmp_evt_o) lvl_q <= 1'b0;
  end

  assign pwm_lvl_o = lvl_q;
  assign pwm_o     = lvl_q && pwm_en_i;

endmodule

// File: rtl/arpwm_timer.sv
module arpwm_timer
  import arpwm_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pwm_o,
  output logic              irq_o
);

  logic [CNT_W-1:0] cnt_q, reload_val, duty_val;
  logic ovf_evt, cmp_evt, cmp_frozen, pwm_lvl, pwm_en, irq_en, ovf_flag;

  arpwm_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .ovf_evt_i  (ovf_evt),
    .rdata_o    (rdata_o),
    .reload_o   (reload_val),
    .duty_o     (duty_val),
    .frozen_o   (cmp_frozen),
    .pwm_en_o   (pwm_en),
    .irq_en_o   (irq_en),
    .ovf_flag_o (ovf_flag)
  );

  arpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .reload_i  (reload_val),
    .cnt_o     (cnt_q),
    .ovf_evt_o (ovf_evt)
  );

  arpwm_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .cnt_i     (cnt_q),
    .ovf_evt_i (ovf_evt),
    .reload_i  (reload_val),
    .duty_i    (duty_val),
    .frozen_i  (cmp_frozen),
    .pwm_en_i  (pwm_en),
    .cmp_evt_o (cmp_evt),
    .pwm_lvl_o (pwm_lvl),
    .pwm_o     (pwm_o)
  );

  assign irq_o = ovf_flag && irq_en;

endmodule

// File: rtl/arpwm_timer_chk.sv
module arpwm_timer_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             ovf_evt,
  input logic             cmp_evt,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] reload_val,
  input logic [CNT_W-1:0] duty_val,
  input logic             cmp_frozen,
  input logic             pwm_lvl,
  input logic             pwm_en,
  input logic             irq_en,
  input logic             ovf_flag,
  input logic             pwm_o,
  input logic             irq_o
);

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !ovf_evt |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  a_r2_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt |=> cnt_q == $past(reload_val));

  a_r3_open_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt && (duty_val >= reload_val) |=> pwm_lvl);

  a_r3_cmp_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_evt |=> !pwm_lvl);

  a_r4_stay_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt && (duty_val < reload_val) |=> !pwm_lvl);

  a_r5_frozen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_frozen && pwm_lvl |=> pwm_lvl);

  a_r8_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt |=> ovf_flag);

  a_r9_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en |-> !irq_o);

  a_r10_pin_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_en |-> !pwm_o);

  a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q) && $stable(pwm_lvl));

endmodule

bind arpwm_timer arpwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .ovf_evt    (ovf_evt),
  .cmp_evt    (cmp_evt),
  .cnt_q      (cnt_q),
  .reload_val (reload_val),
  .duty_val   (duty_val),
  .cmp_frozen (cmp_frozen),
  .pwm_lvl    (pwm_lvl),
  .pwm_en     (pwm_en),
  .irq_en     (irq_en),
  .ovf_flag   (ovf_flag),
  .pwm_o      (pwm_o),
  .irq_o      (irq_o)
);

// File: tb/arpwm_timer_test.sv
module arpwm_timer_test;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       pwm_o, irq_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  arpwm_timer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .pwm_o(pwm_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic wait_rise();
    logic p;
    @(negedge clk_i);
    p = pwm_o;
    forever begin
      @(negedge clk_i);
      if (!p && pwm_o) break;
      p = pwm_o;
    end
  endtask

  task automatic measure(output int hi, output int per);
    int t0;
    wait_rise();
    t0 = cyc;
    hi = 0;
    while (pwm_o) begin
      hi++;
      @(negedge clk_i);
    end
    wait_rise();
    per = cyc - t0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R1 register reset", d, 0);
    end
    check("R1 pwm_o reset", pwm_o, 0);
    check("R1 irq_o reset", irq_o, 0);
  endtask

  task automatic t_basic();
    int hi, per;
    wr(3'd1, 8'h0F); wr(3'd0, 8'hF0);   // reload 0xFF0
    wr(3'd2, 8'h0F); wr(3'd3, 8'hF4);   // duty 0xFF4
    wr(3'd4, 8'h01);
    measure(hi, per);
    check("R2 period 0x1000-0xFF0", per, 16);
    check("R3 high time 0xFF4", hi, 5);
    wr(3'd3, 8'hF9);
    measure(hi, per);
    check("R3 high time 0xFF9", hi, 10);
    check("R2 period unchanged", per, 16);
  endtask

  task automatic t_below();
    int highs = 0;
    wr(3'd3, 8'hE0);                    // duty 0xFE0 < reload
    repeat (20) @(negedge clk_i);
    repeat (40) begin
      @(negedge clk_i);
      if (pwm_o) highs++;
    end
    check("R4 duty below reload stays low", highs, 0);
  endtask

  task automatic t_freeze();
    logic [7:0] d;
    int lows = 0, hi, per;
    wr(3'd3, 8'hF4);                    // duty 0xFF4 again
    wait_rise();
    wr(3'd2, 8'h0F);
    rd(3'd5, d);
    check("R5 frozen status bit", d[1], 1);
    repeat (40) begin
      @(negedge clk_i);
      if (!pwm_o) lows++;
    end
    check("R5 no compare while frozen", lows, 0);
    wr(3'd2, 8'h0E);
    rd(3'd2, d);
    check("R6 duty high not committed early", d, 8'h0F);
    wr(3'd3, 8'hF7);                    // commits 0xEF7 < reload
    rd(3'd5, d);
    check("R6 freeze cleared by low write", d[1], 0);
    repeat (20) @(negedge clk_i);
    repeat (32) begin
      @(negedge clk_i);
      if (pwm_o) lows++;
    end
    check("R6 committed 0xEF7 keeps output low", lows, 0);
    wr(3'd2, 8'h0F); wr(3'd3, 8'hF7);  // duty 0xFF7
    measure(hi, per);
    check("R6 committed 0xFF7 high time", hi, 8);
  endtask

  task automatic t_reload();
    int t0, hi, per;
    wait_rise();
    t0 = cyc;
    wr(3'd0, 8'hE0);                    // reload 0xFE0
    wait_rise();
    check("R7 current period keeps old reload", cyc - t0, 16);
    measure(hi, per);
    check("R7 new period after overflow", per, 32);
    check("R3 high time with reload 0xFE0", hi, 24);
  endtask

  task automatic t_flag_irq();
    logic [7:0] d;
    wait_rise();
    rd(3'd5, d);
    check("R8 flag set by overflow", d[0], 1);
    rd(3'd5, d);
    check("R8 flag cleared by read", d[0], 0);
    check("R9 irq low while disabled", irq_o, 0);
    wr(3'd4, 8'h03);
    repeat (40) @(negedge clk_i);
    check("R9 irq raised with flag and enable", irq_o, 1);
    wait_rise();
    rd(3'd5, d);
    @(negedge clk_i);
    check("R9 irq drops after status read", irq_o, 0);
  endtask

  task automatic t_disable();
    logic [7:0] d;
    int highs = 0;
    wr(3'd4, 8'h00);
    rd(3'd5, d);
    repeat (64) begin
      @(negedge clk_i);
      if (pwm_o) highs++;
    end
    check("R10 pin low while disabled", highs, 0);
    rd(3'd5, d);
    check("R10 counter runs while disabled", d[0], 1);
    wr(3'd4, 8'h01);
  endtask

  task automatic t_tick();
    logic [7:0] d;
    int lows = 0, hi, per;
    wait_rise();
    tick_i = 1'b0;
    rd(3'd5, d);
    repeat (100) begin
      @(negedge clk_i);
      if (!pwm_o) lows++;
    end
    check("R11 level frozen without ticks", lows, 0);
    rd(3'd5, d);
    check("R11 no overflow without ticks", d[0], 0);
    tick_i = 1'b1;
    measure(hi, per);
    check("R11 period after resume", per, 32);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_below();
    t_freeze();
    t_reload();
    t_flag_irq();
    t_disable();
    t_tick();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule